// File: doc/BRIEF.md
# Resolver Serial Read Controller

This block is the host-side master for a resolver-to-digital converter that is read over a three-wire serial link. One start request runs one full read. The block drives the register-select line to ask for either position or velocity. It pulses the sample line low so that the converter latches fresh integrator values. It then lowers chip select and read, toggles the serial clock, and shifts in one 16-bit word, most significant bit first.

The received word is split into a 12-bit angle or velocity value, the returned select bit, a signal-degradation flag and a tracking-loss flag. The block flags an error when the word has an even number of ones, or when the returned select bit differs from the one requested. Results appear with a one-cycle valid pulse. Every timing gap on the link is set in system-clock cycles. The serial clock half period is derived from the system clock frequency so that the serial clock never runs above 25 MHz.

Top module: `rdc_serial_reader`

## Requirements
- R1: After reset and whenever idle, `sample_no`, `cs_no`, `rd_no` and `sclk_o` are high, and `busy_o` and `valid_o` are low.
- R2: A start request in idle drives `sample_no` low for exactly SAMPLE_LOW_CYC cycles, and `rd_no` stays high while sample is low.
- R3: `rdsel_o` takes the value of `sel_pos_i` (1 = position, 0 = velocity) at the accepted start and holds it until the frame ends; `rd_no` falls exactly SEL_SETUP_CYC cycles after `sample_no` returns high.
- R4: `rd_no` falls only while `sclk_o` is high, and `cs_no` is low whenever `rd_no` is low.
- R5: The first `sclk_o` falling edge comes exactly DATA_VALID_CYC cycles after `rd_no` falls; every later low and high phase lasts HALF_CYC = ceil(CLK_HZ / (2 x 25 MHz)) cycles.
- R6: Each frame has exactly 16 `sclk_o` falling edges. `so_i` is captured at each one, MSB first, and `rd_no` rises together with the final `sclk_o` rise. `data_o` is word bits 15..4.
- R7: `is_pos_o` is word bit 3, `dos_o` is word bit 2 and `lot_o` is word bit 1.
- R8: `err_o` is set when the 16-bit word holds an even number of ones (bit 0 is the odd-parity bit).
- R9: `err_o` is set when word bit 3 differs from the requested select value.
- R10: `valid_o` is a single-cycle pulse, given once per frame in the cycle after `rd_no` rises, and the result outputs change only with it.
- R11: A start request while `busy_o` is high is ignored: no extra frame runs and `rdsel_o` does not change.
- R12: After `rd_no` rises, `busy_o` stays high with `rd_no` high for exactly RECOVERY_CYC cycles before a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one read (accepted only when idle) |
| sel_pos_i | input | 1 | Register to read: 1 = position, 0 = velocity |
| busy_o | output | 1 | A read or its recovery gap is in progress |
| sample_no | output | 1 | Sample strobe to the converter, active low |
| rdsel_o | output | 1 | Register select to the converter |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read / frame strobe, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| so_i | input | 1 | Serial data from the converter |
| data_o | output | 12 | Received angle or velocity value |
| is_pos_o | output | 1 | Returned select bit (1 = unsigned position, 0 = signed velocity) |
| dos_o | output | 1 | Signal-degradation flag from the word |
| lot_o | output | 1 | Tracking-loss flag from the word |
| valid_o | output | 1 | One-cycle pulse when results update |
| err_o | output | 1 | Parity or select mismatch in the last word |

## Verification
The bench sets CLK_HZ to 200 MHz, so the derived half period is 4 cycles and the 25 MHz limit is exercised at its rounding point. It uses a sample-low time of 3, a select setup of 2, a recovery gap of 5, and a data-valid delay of 1, the smallest legal value. With a one-cycle data-valid delay, a converter model that updates half a cycle after each pin edge is only just in time for the first capture, so any off-by-one in the MSB capture shows up. These short gaps also let back-to-back reads, stray start pulses in mid-frame, corrupted parity and wrong select bits all be covered within a few thousand cycles.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
  localparam int FRAME_W = 16;
  localparam int ANGLE_W = 12;
  localparam int SEL_BIT = 3;
  localparam int DOS_BIT = 2;
  localparam int LOT_BIT = 1;

  typedef struct packed {
    logic [ANGLE_W-1:0] angle;
    logic               is_pos;
    logic               dos;
    logic               lot;
  } rdc_fields_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rdc_seq.sv
`timescale 1ns/1ps
module rdc_seq #(
  parameter int SAMPLE_LOW_CYC = 4,
  parameter int SEL_SETUP_CYC  = 2,
  parameter int DATA_VALID_CYC = 3,
  parameter int RECOVERY_CYC   = 6,
  parameter int HALF_CYC       = 2,
  parameter int FRAME_W        = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sel_i,
  output logic busy_o,
  output logic sample_no,
  output logic rdsel_o,
  output logic cs_no,
  output logic rd_no,
  output logic sclk_o,
  output logic cap_o,
  output logic done_o
);
  localparam int MAXC = rdc_pkg::max2(rdc_pkg::max2(SAMPLE_LOW_CYC, SEL_SETUP_CYC),
                        rdc_pkg::max2(rdc_pkg::max2(DATA_VALID_CYC, RECOVERY_CYC), HALF_CYC));
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam int BIT_W = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAMPLE, ST_SETUP, ST_DVALID, ST_LO, ST_HI, ST_RECOV
  } st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bits_q;
  logic             tick;
  logic             last_bit;

  assign tick     = (cnt_q == '0);
  assign last_bit = (bits_q == BIT_W'(FRAME_W));
  assign busy_o   = (st_q != ST_IDLE);
  // capture coincides with each falling sclk edge
  assign cap_o    = tick && ((st_q == ST_DVALID) || (st_q == ST_HI));
  assign done_o   = tick && (st_q == ST_LO) && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      bits_q    <= '0;
      sample_no <= 1'b1;
      rdsel_o   <= 1'b1;
      cs_no     <= 1'b1;
      rd_no     <= 1'b1;
      sclk_o    <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          rdsel_o   <= sel_i;
          sample_no <= 1'b0;
          cnt_q     <= CNT_W'(SAMPLE_LOW_CYC - 1);
          st_q      <= ST_SAMPLE;
        end
        ST_SAMPLE: if (tick) begin
          sample_no <= 1'b1;
          cs_no     <= 1'b0;
          cnt_q     <= CNT_W'(SEL_SETUP_CYC - 1);
          st_q      <= ST_SETUP;
        end else cnt_q <= cnt_q - 1'b1;
        ST_SETUP: if (tick) begin
          rd_no <= 1'b0;
          cnt_q <= CNT_W'(DATA_VALID_CYC - 1);
          st_q  <= ST_DVALID;
        end else cnt_q <= cnt_q - 1'b1;
        ST_DVALID: if (tick) begin
          sclk_o <= 1'b0;
          bits_q <= BIT_W'(1);
          cnt_q  <= CNT_W'(HALF_CYC - 1);
          st_q   <= ST_LO;
        end else cnt_q <= cnt_q - 1'b1;
        ST_LO: if (tick) begin
          sclk_o <= 1'b1;
          if (last_bit) begin
            rd_no <= 1'b1;
            cs_no <= 1'b1;
            cnt_q <= CNT_W'(RECOVERY_CYC - 1);
            st_q  <= ST_RECOV;
          end else begin
            cnt_q <= CNT_W'(HALF_CYC - 1);
            st_q  <= ST_HI;
          end
        end else cnt_q <= cnt_q - 1'b1;
        ST_HI: if (tick) begin
          sclk_o <= 1'b0;
          bits_q <= bits_q + 1'b1;
          cnt_q  <= CNT_W'(HALF_CYC - 1);
          st_q   <= ST_LO;
        end else cnt_q <= cnt_q - 1'b1;
        ST_RECOV: if (tick) st_q <= ST_IDLE;
                  else      cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdc_shift_in.sv
`timescale 1ns/1ps
module rdc_shift_in #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_o <= '0;
    else if (cap_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/rdc_word_check.sv
`timescale 1ns/1ps
module rdc_word_check
  import rdc_pkg::*;
(
  input  logic [FRAME_W-1:0] word_i,
  input  logic               req_pos_i,
  output rdc_fields_t        fields_o,
  output logic               par_err_o,
  output logic               sel_err_o
);
  assign fields_o.angle  = word_i[FRAME_W-1 -: ANGLE_W];
  assign fields_o.is_pos = word_i[SEL_BIT];
  assign fields_o.dos    = word_i[DOS_BIT];
  assign fields_o.lot    = word_i[LOT_BIT];
  assign par_err_o       = ~^word_i;
  assign sel_err_o       = word_i[SEL_BIT] ^ req_pos_i;
endmodule

// File: rtl/rdc_serial_reader.sv
`timescale 1ns/1ps
module rdc_serial_reader
  import rdc_pkg::*;
#(
  parameter int CLK_HZ         = 100_000_000,
  parameter int SCLK_MAX_HZ    = 25_000_000,
  parameter int SAMPLE_LOW_CYC = 4,
  parameter int SEL_SETUP_CYC  = 2,
  parameter int DATA_VALID_CYC = 3,
  parameter int RECOVERY_CYC   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               sel_pos_i,
  output logic               busy_o,
  output logic               sample_no,
  output logic               rdsel_o,
  output logic               cs_no,
  output logic               rd_no,
  output logic               sclk_o,
  input  logic               so_i,
  output logic [ANGLE_W-1:0] data_o,
  output logic               is_pos_o,
  output logic               dos_o,
  output logic               lot_o,
  output logic               valid_o,
  output logic               err_o
);
  localparam int HALF_RAW = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic               cap, done;
  logic [FRAME_W-1:0] word;
  rdc_fields_t        fields;
  logic               par_err, sel_err;

  rdc_seq #(
    .SAMPLE_LOW_CYC (SAMPLE_LOW_CYC),
    .SEL_SETUP_CYC  (SEL_SETUP_CYC),
    .DATA_VALID_CYC (DATA_VALID_CYC),
    .RECOVERY_CYC   (RECOVERY_CYC),
    .HALF_CYC       (HALF_CYC),
    .FRAME_W        (FRAME_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .sel_i     (sel_pos_i),
    .busy_o, .sample_no, .rdsel_o, .cs_no, .rd_no, .sclk_o,
    .cap_o     (cap),
    .done_o    (done)
  );

  rdc_shift_in #(.W(FRAME_W)) u_shift (
    .clk_i, .rst_ni,
    .cap_i  (cap),
    .bit_i  (so_i),
    .word_o (word)
  );

  rdc_word_check u_check (
    .word_i    (word),
    .req_pos_i (rdsel_o),
    .fields_o  (fields),
    .par_err_o (par_err),
    .sel_err_o (sel_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      is_pos_o <= 1'b0;
      dos_o    <= 1'b0;
      lot_o    <= 1'b0;
      err_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= done;
      if (done) begin
        data_o   <= fields.angle;
        is_pos_o <= fields.is_pos;
        dos_o    <= fields.dos;
        lot_o    <= fields.lot;
        err_o    <= par_err | sel_err;
      end
    end
  end
endmodule

// File: rtl/rdc_serial_reader_chk.sv
`timescale 1ns/1ps
module rdc_serial_reader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        sel_pos_i,
  input logic        busy_o,
  input logic        sample_no,
  input logic        rdsel_o,
  input logic        cs_no,
  input logic        rd_no,
  input logic        sclk_o,
  input logic        so_i,
  input logic [11:0] data_o,
  input logic        is_pos_o,
  input logic        dos_o,
  input logic        lot_o,
  input logic        valid_o,
  input logic        err_o
);
  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sample_no && cs_no && rd_no && sclk_o && !valid_o));

  p_sample_excl_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_no |-> rd_no);

  p_sel_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> $stable(rdsel_o));

  p_rd_fall_sclk_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> sclk_o);

  p_cs_covers_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !cs_no);

  p_sclk_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> !rd_no);

  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_after_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rd_no && busy_o));

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o) && $stable(err_o) && $stable(is_pos_o));

  p_start_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rdsel_o));
endmodule

bind rdc_serial_reader rdc_serial_reader_chk u_chk (.*);

// File: tb/rdc_serial_reader_test.sv
`timescale 1ns/1ps
module rdc_serial_reader_test;
  localparam int CLK_HZ = 200_000_000;
  localparam int SL = 3, SS = 2, DV = 1, REC = 5;
  localparam int HALF = 4;   // ceil(200M / 50M)

  typedef struct packed {
    logic [11:0] data;
    logic        is_pos;
    logic        dos;
    logic        lot;
    logic        err;
    logic        sel;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sel = 1'b1, so;
  logic busy, sample_n, rdsel, cs_n, rd_n, sclk;
  logic [11:0] data;
  logic is_pos, dos, lot, valid, err;

  int n_chk = 0, n_bad = 0, n_valid = 0, n_push = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rdc_serial_reader #(
    .CLK_HZ(CLK_HZ), .SAMPLE_LOW_CYC(SL), .SEL_SETUP_CYC(SS),
    .DATA_VALID_CYC(DV), .RECOVERY_CYC(REC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sel_pos_i(sel),
    .busy_o(busy), .sample_no(sample_n), .rdsel_o(rdsel), .cs_no(cs_n),
    .rd_no(rd_n), .sclk_o(sclk), .so_i(so), .data_o(data), .is_pos_o(is_pos),
    .dos_o(dos), .lot_o(lot), .valid_o(valid), .err_o(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model: reacts half a cycle after pin edges
  logic [15:0] pos_word = '0, vel_word = '0, so_sr = '0;
  logic s_prev_rd = 1'b1, s_prev_sclk = 1'b1;
  assign so = so_sr[15];
  always @(negedge clk) begin
    if (s_prev_rd && !rd_n) so_sr <= rdsel ? pos_word : vel_word;
    else if (!s_prev_sclk && sclk && !rd_n) so_sr <= {so_sr[14:0], 1'b0};
    s_prev_rd   <= rd_n;
    s_prev_sclk <= sclk;
  end

  function automatic logic [15:0] mk_word(input logic [11:0] a, input logic sb,
                                          input logic d, input logic l, input logic bad);
    logic [14:0] up;
    up = {a, sb, d, l};
    return {up, ~(^up) ^ bad};
  endfunction

  // monitor: protocol timing and scoreboard
  int run_s = 0, ss_cnt = 0, sc_run = 0, falls = 0, rec_cnt = 0;
  bit in_setup = 0, in_frame = 0, in_rec = 0;
  logic m_rd = 1'b1, m_sclk = 1'b1, m_valid = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!sample_n) run_s++;
    else if (run_s != 0) begin
      chk("R2", "sample low cycles", run_s, SL);
      run_s = 0; in_setup = 1; ss_cnt = 1;
    end else if (in_setup) begin
      if (rd_n) ss_cnt++;
    end
    if (in_frame) begin
      if (sclk == m_sclk) sc_run++;
      else begin
        if (!sclk) begin
          if (falls == 0) chk("R5", "rd to first fall", sc_run, DV);
          else            chk("R5", "sclk high phase", sc_run, HALF);
          falls++;
        end else chk("R5", "sclk low phase", sc_run, HALF);
        sc_run = 1;
      end
    end
    if (m_rd && !rd_n) begin
      chk("R3", "setup cycles", ss_cnt, SS);
      in_setup = 0;
      chk("R4", "sclk high at rd fall", int'(sclk), 1);
      chk("R4", "cs low at rd fall", int'(cs_n), 0);
      if (q.size() != 0) chk("R3", "rdsel", int'(rdsel), int'(q[0].sel));
      in_frame = 1; falls = 0; sc_run = 1;
    end
    if (in_rec) begin
      if (busy) rec_cnt++;
      else begin chk("R12", "recovery cycles", rec_cnt, REC); in_rec = 0; end
    end
    if (!m_rd && rd_n) begin
      chk("R6", "falling edges per frame", falls, 16);
      chk("R6", "sclk high at rd rise", int'(sclk), 1);
      in_frame = 0; in_rec = 1; rec_cnt = 1;
    end
    if (valid) begin
      n_valid++;
      if (m_valid) chk("R10", "valid width", 2, 1);
      if (q.size() == 0) chk("R11", "unexpected valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R6", "data", int'(data), int'(e.data));
        chk("R7", "is_pos", int'(is_pos), int'(e.is_pos));
        chk("R7", "dos", int'(dos), int'(e.dos));
        chk("R7", "lot", int'(lot), int'(e.lot));
        chk("R8/R9", "err", int'(err), int'(e.err));
      end
    end
    m_rd = rd_n; m_sclk = sclk; m_valid = valid;
  end

  // driver: sets the converter words, pushes the expectation, pulses start
  task automatic do_read(input logic s, input logic [11:0] a_pos, input logic [11:0] a_vel,
                         input logic d, input logic l, input logic bad_par, input logic wrong_sel);
    exp_t e;
    while (busy) @(negedge clk);
    pos_word = mk_word(a_pos, ~wrong_sel, d, l, bad_par);
    vel_word = mk_word(a_vel, wrong_sel, d, l, bad_par);
    e.data = s ? a_pos : a_vel;
    e.is_pos = s ^ wrong_sel;
    e.dos = d; e.lot = l;
    e.err = bad_par | wrong_sel;   // R8 parity, R9 select mismatch
    e.sel = s;
    q.push_back(e); n_push++;
    sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "sample_no in reset", int'(sample_n), 1);
    chk("R1", "valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle pins", int'({sample_n, cs_n, rd_n, sclk}), 4'hF);
    chk("R1", "idle busy", int'(busy), 0);

    do_read(1'b1, 12'hABC, 12'h123, 1'b1, 1'b0, 1'b0, 1'b0);  // R6 R7 position
    do_read(1'b0, 12'h555, 12'h800, 1'b0, 1'b1, 1'b0, 1'b0);  // velocity, negative
    do_read(1'b1, 12'h000, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0);  // all-zero angle
    do_read(1'b1, 12'hFFF, 12'h000, 1'b1, 1'b1, 1'b1, 1'b0);  // R8 bad parity
    do_read(1'b0, 12'h0F0, 12'h7FF, 1'b0, 0'b0, 1'b0, 1'b1);  // R9 wrong select
    do_read(1'b0, 12'h3C3, 12'h9A5, 1'b1, 1'b0, 1'b1, 1'b1);  // both errors

    // R11: stray start in mid-frame with the opposite select
    do_read(1'b1, 12'h246, 12'h135, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "rdsel after stray start", int'(rdsel), 1);
    chk("R11", "still busy", int'(busy), 1);

    for (int i = 0; i < 4; i++)  // back-to-back reads, R12 gap
      do_read(i[0], 12'(i * 12'h311), 12'(12'hFFF - i), i[1], ~i[0], 1'b0, 1'b0);

    while (busy || q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R11", "frames completed", n_valid, n_push);
    chk("R1", "idle after run", int'({sample_n, cs_n, rd_n, sclk}), 4'hF);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule